// File: doc/BRIEF.md
# Shared Display Auxiliary Channel Ownership Arbiter

This block decides who may drive one shared DisplayPort AUX channel: host software or an embedded microcontroller. Software sees a small register-style view. It has a one-cycle request strobe, a one-cycle "finished" strobe and a two-bit ownership code that it reads back after asking. The microcontroller holds a level request. It keeps the channel for as long as that request stays high.

Before software can be granted the channel, the channel must be switched on. In builds that have reset support, software switches the channel on and puts it into reset with the same configuration write. A sequencer then counts a fixed latency and raises a reset-done flag. Software then clears the reset bit, and the flag drops one cycle later. Only then can a software request succeed. Neither owner is ever preempted. Each holder keeps the grant until it lets go.

Top module: `aux_chan_arbiter`

## Requirements
- R1: Out of reset, the ownership code reads 0 (no owner) and channel enable, channel reset and reset-done are all 0. The code is 1 for software and 2 for the microcontroller.
- R2: While the code reads 2, a software request strobe is refused and the code stays 2.
- R3: A software request strobe in a cycle where the code is 0, the microcontroller is not requesting, enable is 1, channel reset is 0 and reset-done is 0 makes the code read 1 after that clock edge.
- R4: A finished strobe while the code is 1 makes the code read 0 after that edge. A finished strobe while the code is 2 has no effect.
- R5: While channel enable is 0, a software request strobe is refused and the code stays 0.
- R6: With reset support, a configuration write that sets enable and reset raises reset-done exactly RST_LAT+1 cycles after the write edge. A software request made while channel reset is 1 is refused.
- R7: After a configuration write that clears reset, reset-done is still 1 in the following cycle and reads 0 one cycle after that.
- R8: If the microcontroller request and a software request strobe arrive in the same cycle while the code is 0, the microcontroller wins (code 2). A microcontroller request while software holds the channel leaves the code at 1.
- R9: The microcontroller keeps the channel while its request is high. The code returns to 0 one cycle after the request drops. From code 0, a high microcontroller request gives code 2 on the next edge.
- R10: With reset support disabled (HAS_RESET=0), the reset bit of a configuration write is ignored. Channel reset and reset-done stay 0, and enable alone is enough for a software grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Channel enable value to write |
| cfgReset | input | 1 | Channel reset value to write |
| swReqWr | input | 1 | Software request strobe |
| swDoneWr | input | 1 | Software finished strobe |
| mcuReq | input | 1 | Microcontroller level request |
| ownStatus | output | 2 | Ownership code: 0 none, 1 software, 2 microcontroller |
| chanEnable | output | 1 | Channel enable held by the block |
| chanReset | output | 1 | Channel reset held by the block |
| resetDone | output | 1 | Reset-done handshake flag |

## Verification
The assertions assume the following about the inputs:
- The software request, finished and configuration strobes each last a single cycle.
- The microcontroller request is a level that is held for the whole of its ownership.
- Software clears the reset bit only after reset-done has been seen high.

The directed stimulus changes inputs only on the falling edge. It pulses each strobe for exactly one clock and keeps the microcontroller request steady across each scenario. It lowers the reset bit only after waiting for reset-done. This keeps every run inside those assumptions, while still exercising the simultaneous-request tie and requests made during reset.

// File: rtl/aux_arb_pkg.sv
package aux_arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_SW   = 2'd1,
    OWN_MCU  = 2'd2
  } own_e;

  typedef enum logic [1:0] {
    SEQ_OFF,
    SEQ_WAIT,
    SEQ_DONE
  } seq_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic doneSet;
    logic doneClr;
  } seq_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic chanRst;
    logic cntHit;
    logic swReady;
  } dp_stat_t;
endpackage

// File: rtl/aux_arb_dp.sv
module aux_arb_dp
  import aux_arb_pkg::*;
#(
  parameter bit HAS_RESET = 1'b1,
  parameter int RST_LAT   = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWr,
  input  logic        cfgEnable,
  input  logic        cfgReset,
  input  seq_strobe_t strb,
  output logic        chanEn,
  output logic        chanRst,
  output logic        rstDone,
  output dp_stat_t    stat
);
  localparam int CW = $clog2(RST_LAT + 1);
  localparam logic [CW-1:0] HIT_VAL = CW'(RST_LAT - 1);

  logic [CW-1:0] latCnt;

  always_ff @(posedge clk) begin
    if (!rstN) chanEn <= 1'b0;
    else if (cfgWr) chanEn <= cfgEnable;
  end

  generate
    if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk) begin
        if (!rstN) chanRst <= 1'b0;
        else if (cfgWr) chanRst <= cfgReset;
      end
    end else begin : g_noRst
      assign chanRst = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) latCnt <= '0;
    else if (strb.cntClr) latCnt <= '0;
    else if (strb.cntInc) latCnt <= latCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rstDone <= 1'b0;
    else if (strb.doneClr) rstDone <= 1'b0;
    else if (strb.doneSet) rstDone <= 1'b1;
  end

  always_comb begin
    stat.chanRst = chanRst;
    stat.cntHit  = (latCnt == HIT_VAL);
    stat.swReady = chanEn && !chanRst && !rstDone;
  end

  AST_DONE_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    !chanRst |=> !rstDone); // R7
  AST_DONE_NEEDS_RST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstDone) |-> $past(chanRst)); // R6
endmodule

// File: rtl/aux_arb_ctl.sv
module aux_arb_ctl
  import aux_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swReqWr,
  input  logic        swDoneWr,
  input  logic        mcuReq,
  input  dp_stat_t    stat,
  output seq_strobe_t strb,
  output logic [1:0]  ownStatus
);
  seq_e seqState, seqNext;
  own_e own, ownNext;

  // reset handshake sequencer
  always_comb begin
    strb    = '0;
    seqNext = seqState;
    unique case (seqState)
      SEQ_OFF: if (stat.chanRst) begin
        strb.cntClr = 1'b1;
        seqNext     = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (!stat.chanRst) begin
          strb.cntClr = 1'b1;
          seqNext     = SEQ_OFF;
        end else if (stat.cntHit) begin
          strb.doneSet = 1'b1;
          seqNext      = SEQ_DONE;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      SEQ_DONE: if (!stat.chanRst) begin
        strb.doneClr = 1'b1;
        seqNext      = SEQ_OFF;
      end
      default: seqNext = SEQ_OFF;
    endcase
  end

  // ownership arbitration: no preemption, microcontroller wins ties from idle
  always_comb begin
    ownNext = own;
    unique case (own)
      OWN_IDLE: begin
        if (mcuReq) ownNext = OWN_MCU;
        else if (swReqWr && stat.swReady) ownNext = OWN_SW;
      end
      OWN_SW:  if (swDoneWr) ownNext = OWN_IDLE;
      OWN_MCU: if (!mcuReq) ownNext = OWN_IDLE;
      default: ownNext = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState <= SEQ_OFF;
      own      <= OWN_IDLE;
    end else begin
      seqState <= seqNext;
      own      <= ownNext;
    end
  end

  assign ownStatus = own;

  AST_MCU_BLOCKS_SW: assert property (@(posedge clk) disable iff (!rstN)
    (own == OWN_MCU) |=> (own != OWN_SW)); // R2
  AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (own == OWN_SW && $past(own) != OWN_SW) |-> $past(swReqWr && stat.swReady)); // R3
  AST_SW_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    (own == OWN_SW && !swDoneWr) |=> (own == OWN_SW)); // R8
  AST_MCU_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (own == OWN_MCU && mcuReq) |=> (own == OWN_MCU)); // R9
endmodule

// File: rtl/aux_chan_arbiter.sv
module aux_chan_arbiter
  import aux_arb_pkg::*;
#(
  parameter bit HAS_RESET = 1'b1,
  parameter int RST_LAT   = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic       cfgEnable,
  input  logic       cfgReset,
  input  logic       swReqWr,
  input  logic       swDoneWr,
  input  logic       mcuReq,
  output logic [1:0] ownStatus,
  output logic       chanEnable,
  output logic       chanReset,
  output logic       resetDone
);
  seq_strobe_t strb;
  dp_stat_t    stat;

  aux_arb_dp #(.HAS_RESET(HAS_RESET), .RST_LAT(RST_LAT)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEnable(cfgEnable),
    .cfgReset(cfgReset), .strb(strb), .chanEn(chanEnable),
    .chanRst(chanReset), .rstDone(resetDone), .stat(stat)
  );

  aux_arb_ctl u_ctl (
    .clk(clk), .rstN(rstN), .swReqWr(swReqWr), .swDoneWr(swDoneWr),
    .mcuReq(mcuReq), .stat(stat), .strb(strb), .ownStatus(ownStatus)
  );
endmodule

// File: tb/sim_aux_chan_arbiter.sv
`timescale 1ns/100ps
module sim_aux_chan_arbiter;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 0, cfgEnable = 0, cfgReset = 0, swReqWr = 0, swDoneWr = 0, mcuReq = 0;
  logic [1:0] ownStatus;
  logic chanEnable, chanReset, resetDone;
  logic cfgWr1 = 0, cfgEnable1 = 0, cfgReset1 = 0, swReqWr1 = 0;
  logic [1:0] ownStatus1;
  logic chanEnable1, chanReset1, resetDone1;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  aux_chan_arbiter #(.HAS_RESET(1'b1), .RST_LAT(LAT)) u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEnable(cfgEnable), .cfgReset(cfgReset),
    .swReqWr(swReqWr), .swDoneWr(swDoneWr), .mcuReq(mcuReq), .ownStatus(ownStatus),
    .chanEnable(chanEnable), .chanReset(chanReset), .resetDone(resetDone));

  aux_chan_arbiter #(.HAS_RESET(1'b0), .RST_LAT(LAT)) u1 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr1), .cfgEnable(cfgEnable1), .cfgReset(cfgReset1),
    .swReqWr(swReqWr1), .swDoneWr(1'b0), .mcuReq(1'b0), .ownStatus(ownStatus1),
    .chanEnable(chanEnable1), .chanReset(chanReset1), .resetDone(resetDone1));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic en, input logic rs);
    @(negedge clk); cfgWr = 1; cfgEnable = en; cfgReset = rs;
    @(negedge clk); cfgWr = 0;
  endtask

  task automatic pulseReq;
    @(negedge clk); swReqWr = 1;
    @(negedge clk); swReqWr = 0;
  endtask

  task automatic pulseDone;
    @(negedge clk); swDoneWr = 1;
    @(negedge clk); swDoneWr = 0;
  endtask

  task automatic t_reset;
    chk("R1 status", ownStatus, 0);
    chk("R1 enable", chanEnable, 0);
    chk("R1 chanReset", chanReset, 0);
    chk("R1 resetDone", resetDone, 0);
  endtask

  task automatic t_disabled;
    pulseReq();
    chk("R5 refused when disabled", ownStatus, 0);
  endtask

  task automatic t_enable_seq;
    int n;
    cfgWrite(1, 1);
    n = 0;
    while (!resetDone && n < 20) begin
      @(negedge clk); n++;
    end
    chk("R6 reset-done latency", n, LAT + 1);
    pulseReq();
    chk("R6 refused during reset", ownStatus, 0);
    cfgWrite(1, 0);
    chk("R7 done held one cycle", resetDone, 1);
    @(negedge clk);
    chk("R7 done falls", resetDone, 0);
  endtask

  task automatic t_sw_grant;
    pulseReq();
    chk("R3 software grant", ownStatus, 1);
    mcuReq = 1;
    repeat (3) @(negedge clk);
    chk("R8 no preemption of software", ownStatus, 1);
    pulseDone();
    chk("R4 release to idle", ownStatus, 0);
    @(negedge clk);
    chk("R9 microcontroller takes idle channel", ownStatus, 2);
  endtask

  task automatic t_mcu_block;
    pulseReq();
    chk("R2 refused while mcu owns", ownStatus, 2);
    pulseDone();
    chk("R4 done ignored for mcu", ownStatus, 2);
    mcuReq = 0;
    @(negedge clk);
    chk("R9 mcu release", ownStatus, 0);
  endtask

  task automatic t_tie;
    @(negedge clk); mcuReq = 1; swReqWr = 1;
    @(negedge clk); swReqWr = 0;
    chk("R8 tie goes to mcu", ownStatus, 2);
    mcuReq = 0;
    @(negedge clk);
    chk("R9 release after tie", ownStatus, 0);
    cfgWrite(0, 0);
    pulseReq();
    chk("R5 refused after disable", ownStatus, 0);
  endtask

  task automatic t_no_reset_variant;
    @(negedge clk); cfgWr1 = 1; cfgEnable1 = 1; cfgReset1 = 1;
    @(negedge clk); cfgWr1 = 0;
    chk("R10 reset bit ignored", chanReset1, 0);
    repeat (LAT + 3) @(negedge clk);
    chk("R10 no reset-done", resetDone1, 0);
    @(negedge clk); swReqWr1 = 1;
    @(negedge clk); swReqWr1 = 0;
    chk("R10 grant with enable only", ownStatus1, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_enable_seq();
    t_sw_grant();
    t_mcu_block();
    t_tie();
    t_no_reset_variant();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule